// File: doc/BRIEF.md
# Double-Buffered Parallel-to-Serial Configuration Loader

This block takes configuration bytes from a host on a small parallel write bus and streams them out one bit at a time, together with a configuration clock that it makes itself. A write counts only while all three chip selects are in their active state and the write strobe is low. The byte is taken when the strobe is released, so the host may drop the data right after that.

The path holds two bytes. A holding register takes the byte from the bus. A shift register then sends it out most-significant bit first, as a group of eight configuration-clock pulses. The configuration clock is the system clock divided by an even ratio `DIV`, and it pulses only while a byte is being shifted. A ready output tells the host when the holding register can take the next byte.

How long ready stays low depends on how full the buffers are. If the shifter is idle, the holding register empties at the next falling phase of the divider, so ready stays low for at most one configuration-clock period. If the shifter is still busy with the previous byte, the holding register has to wait until that byte's eighth bit has been sent.

Top module: `cfg_byte_loader`

## Requirements
- R1: A write is recognised only when `sel0_n`=0, `sel1_n`=0, `sel2`=1 and `wr_n`=0 in the same sampled cycle. If any one of these is missing, nothing is loaded and `ready` stays 1.
- R2: The byte loaded is the value on `din` in the last cycle the write was active. Changes on `din` after the strobe is released have no effect.
- R3: After an accepted write is released, `ready` reads 0 after the next rising system-clock edge.
- R4: If a byte is written while the shifter is idle, `ready` returns to 1 within `DIV`+1 system-clock cycles.
- R5: If a byte is written while the previous byte has not finished shifting, `ready` stays 0 until that previous byte's eighth bit period ends. This is at least 6·`DIV` cycles when the write follows right after ready, and never more than 9·`DIV`+2 cycles.
- R6: Each accepted byte appears on `cfg_dout` as exactly 8 rising edges of `cfg_clk`, bit 7 first and bit 0 last. Bytes come out in the order they were accepted.
- R7: `cfg_dout` changes only while `cfg_clk` is low. It is stable through every high phase of `cfg_clk`.
- R8: When no byte is pending, `cfg_clk` stays 0 and `cfg_dout` stays 1. This holds from reset on.
- R9: A write completed while `ready` is 0 is dropped. The holding register is not changed and no extra byte is sent.
- R10: A write started in any cycle after `ready` returns to 1, including the first one, is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel0_n | input | 1 | Chip select, active low |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| wr_n | input | 1 | Write strobe, active low; byte taken on release |
| din | input | 8 | Parallel data byte |
| ready | output | 1 | 1 = holding register free for a new write |
| cfg_clk | output | 1 | Generated configuration clock (pulses only while shifting) |
| cfg_dout | output | 1 | Serial data, valid at each rising `cfg_clk` |

## Verification
Two things can happen on the same edge: the holding register being loaded from the bus, and the shifter reaching its falling-phase tick, where it either moves the held byte inward or shifts out its last bit. The bench makes this happen by sweeping the delay between the return of `ready` and the next write across every phase of the divider. It does this both while the shifter is idle and while it is still sending. Every byte is checked by the scoreboard against the serial stream, in order and with nothing lost or doubled, and each busy interval is checked against its short or long bound.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  // Longest legal busy interval in system cycles for a divide ratio.
  function automatic int unsigned busy_limit(input int unsigned div);
    return 9 * div + 2;
  endfunction

  // Divider phase at which the configuration clock falls.
  function automatic int unsigned fall_phase(input int unsigned div);
    return div / 2;
  endfunction

endpackage

// File: rtl/cfg_wr_port.sv
module cfg_wr_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel0_n,
  input  logic         sel1_n,
  input  logic         sel2,
  input  logic         wr_n,
  input  logic [W-1:0] din,
  input  logic         take,
  output logic [W-1:0] hold_q,
  output logic         hold_full,
  output logic         wr_end
);

  logic         wr_on;
  logic         act_q;
  logic [W-1:0] din_q;

  assign wr_on  = ~sel0_n & ~sel1_n & sel2 & ~wr_n;
  assign wr_end = act_q & ~wr_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      din_q     <= '0;
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else begin
      act_q <= wr_on;
      if (wr_on) din_q <= din;
      if (wr_end && !hold_full) begin
        hold_q    <= din_q;
        hold_full <= 1'b1;
      end else if (take) begin
        hold_full <= 1'b0;
      end
    end
  end

  // R1
  load_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_full) |-> $past(act_q));

  // R9
  drop_keeps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_end && hold_full) |=> (hold_q == $past(hold_q)));

endmodule

// File: rtl/cfg_clkgen.sv
module cfg_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic rise_tick,
  output logic fall_tick
);
  import cfg_loader_pkg::*;

  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int FALL = fall_phase(DIV);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (cnt == CW'(DIV - 1))  cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end

  assign rise_tick = (cnt == '0);
  assign fall_tick = (cnt == CW'(FALL));

endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise_tick,
  input  logic         fall_tick,
  input  logic [W-1:0] hold_q,
  input  logic         hold_full,
  output logic         take,
  output logic         ck_q,
  output logic         dout_q
);

  localparam int BW = $clog2(W);

  logic [W-1:0]  sreg;
  logic [BW-1:0] bitn;
  logic          shifting;
  logic          last_bit;

  assign last_bit = (bitn == BW'(W - 1));
  assign take     = fall_tick & hold_full & (~shifting | last_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg     <= '0;
      bitn     <= '0;
      shifting <= 1'b0;
      ck_q     <= 1'b0;
      dout_q   <= 1'b1;
    end else if (fall_tick) begin
      ck_q <= 1'b0;
      if (shifting && !last_bit) begin
        sreg   <= sreg << 1;
        dout_q <= sreg[W-2];
        bitn   <= bitn + 1'b1;
      end else if (hold_full) begin
        sreg     <= hold_q;
        dout_q   <= hold_q[W-1];
        bitn     <= '0;
        shifting <= 1'b1;
      end else begin
        shifting <= 1'b0;
        dout_q   <= 1'b1;
      end
    end else if (rise_tick && shifting) begin
      ck_q <= 1'b1;
    end
  end

  // R7
  dout_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_q && $past(ck_q)) |-> $stable(dout_q));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shifting |-> (dout_q && !ck_q));

  // R6
  pulse_only_shifting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ck_q) |-> shifting);

endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel0_n,
  input  logic       sel1_n,
  input  logic       sel2,
  input  logic       wr_n,
  input  logic [7:0] din,
  output logic       ready,
  output logic       cfg_clk,
  output logic       cfg_dout
);
  import cfg_loader_pkg::*;

  localparam int W        = 8;
  localparam int BUSY_MAX = busy_limit(DIV);
  localparam int RW       = $clog2(BUSY_MAX + 2);

  logic [W-1:0] hold_q;
  logic         hold_full;
  logic         wr_end;
  logic         take;
  logic         rise_tick;
  logic         fall_tick;

  cfg_wr_port #(.W(W)) u_port (
    .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1_n(sel1_n), .sel2(sel2),
    .wr_n(wr_n), .din(din), .take(take), .hold_q(hold_q),
    .hold_full(hold_full), .wr_end(wr_end)
  );

  cfg_clkgen #(.DIV(DIV)) u_gen (
    .clk(clk), .rst_n(rst_n), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  cfg_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .hold_q(hold_q), .hold_full(hold_full), .take(take),
    .ck_q(cfg_clk), .dout_q(cfg_dout)
  );

  assign ready = ~hold_full;

  // Length of the current busy run, for the bound check.
  logic [RW-1:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_run <= '0;
    else if (hold_full) busy_run <= busy_run + 1'b1;
    else                busy_run <= '0;
  end

  // R5
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= RW'(BUSY_MAX));

endmodule

// File: tb/cfg_byte_loader_test.sv
module cfg_byte_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel0_n = 1'b1, sel1_n = 1'b1, sel2 = 1'b0, wr_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic ready, cfg_clk, cfg_dout;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  int bytes_seen = 0;
  int pulses = 0;
  bit stab_bad = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_byte_loader #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1_n(sel1_n), .sel2(sel2),
    .wr_n(wr_n), .din(din), .ready(ready), .cfg_clk(cfg_clk), .cfg_dout(cfg_dout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: assemble serial bytes and compare with the scoreboard queue.
  logic prev_ck = 1'b0;
  logic prev_do = 1'b1;
  logic [7:0] shreg = 8'h00;
  int nbits = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cfg_clk && prev_ck && cfg_dout !== prev_do) stab_bad = 1'b1; // R7
      if (cfg_clk && !prev_ck) begin
        pulses++;
        shreg = {shreg[6:0], cfg_dout};
        nbits++;
        if (nbits == 8) begin
          nbits = 0;
          bytes_seen++;
          if (exp_q.size() == 0) check(1'b0, "R6 unexpected byte", shreg, -1);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(shreg == e, "R6 serial byte", shreg, e);
          end
        end
      end
    end
    prev_ck = cfg_clk;
    prev_do = cfg_dout;
  end

  // Driver: one bus write; returns the busy length seen after release.
  task automatic do_write(input logic [7:0] v, input logic s0, input logic s1,
                          input logic s2, output int blen);
    @(negedge clk);
    sel0_n = s0; sel1_n = s1; sel2 = s2; din = v; wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_n = 1'b1; din = ~v;
    sel0_n = 1'b1; sel1_n = 1'b1; sel2 = 1'b0;
    blen = 0;
    @(negedge clk);
    while (!ready && blen < 20 * DIV) begin
      blen++;
      @(negedge clk);
    end
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!ready && n < 20 * DIV) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int bl;
    int p0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(ready == 1'b1, "R8 reset ready", ready, 1);
    check(cfg_clk == 1'b0 && cfg_dout == 1'b1, "R8 reset idle", {cfg_clk, cfg_dout}, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 wrong selects: nothing loaded
    do_write(8'h11, 1'b1, 1'b0, 1'b1, bl);
    check(bl == 0, "R1 sel0 inactive", bl, 0);
    do_write(8'h22, 1'b0, 1'b1, 1'b1, bl);
    check(bl == 0, "R1 sel1 inactive", bl, 0);
    do_write(8'h33, 1'b0, 1'b0, 1'b0, bl);
    check(bl == 0, "R1 sel2 inactive", bl, 0);

    // R2 R3 R4 write into idle shifter; din changes after release
    exp_q.push_back(8'hA5);
    do_write(8'hA5, 1'b0, 1'b0, 1'b1, bl);
    check(bl >= 1, "R3 busy after release", bl, 1);
    check(bl <= DIV + 1, "R4 short busy", bl, DIV + 1);

    // R5 R10 write immediately after ready: waits for previous byte
    exp_q.push_back(8'h3C);
    do_write(8'h3C, 1'b0, 1'b0, 1'b1, bl);
    check(bl >= 6 * DIV && bl <= 9 * DIV + 2, "R5 long busy", bl, 8 * DIV);

    // R9 fill holding, then write while busy: dropped
    exp_q.push_back(8'h81);
    @(negedge clk);
    sel0_n = 1'b0; sel1_n = 1'b0; sel2 = 1'b1; din = 8'h81; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; din = 8'h00; sel0_n = 1'b1; sel1_n = 1'b1; sel2 = 1'b0;
    @(negedge clk);
    check(ready == 1'b0, "R3 ready low", ready, 0);
    do_write(8'hEE, 1'b0, 1'b0, 1'b1, bl);
    wait_ready();

    // R10 phase sweep, idle and busy shifter, collision of load and tick
    for (int k = 0; k < 2 * DIV; k++) begin
      logic [7:0] v;
      v = 8'(8'h40 + k * 8'h13);
      repeat (k) @(negedge clk);
      exp_q.push_back(v);
      do_write(v, 1'b0, 1'b0, 1'b1, bl);
      check(bl <= 9 * DIV + 2, "R10 sweep busy bound", bl, 9 * DIV + 2);
      if (k == DIV) repeat (12 * DIV) @(negedge clk);
    end

    repeat (20 * DIV) @(negedge clk);
    check(exp_q.size() == 0, "R6 all bytes sent", exp_q.size(), 0);
    check(bytes_seen == 3 + 2 * DIV, "R9 no dropped byte sent", bytes_seen, 3 + 2 * DIV);
    check(!stab_bad, "R7 dout stable while clock high", stab_bad, 0);
    p0 = pulses;
    repeat (10 * DIV) @(negedge clk);
    check(pulses == p0, "R8 no idle pulses", pulses - p0, 0);
    check(cfg_dout == 1'b1 && cfg_clk == 1'b0, "R8 idle levels", {cfg_clk, cfg_dout}, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule